// File: doc/BRIEF.md
# Ring buffer refill controller with request chaining

This block turns host write requests into a steady stream of pre-encoded bus words for an output sequencer. A request names a start address and a byte count. While a transfer runs, the controller fetches bytes one per cycle through a simple byte read port. It stores each byte as a 9-bit word (eight data bits plus an odd-parity bit) in a 256-slot circular store. The sequencer reads the slot at its own position and advances with a take strobe.

Refill is metered. The writer may run at most to a fill limit, which starts one full ring ahead. Each time the consumer passes the middle or the end of the ring, one half-ring of credit becomes pending. That credit is granted only when the copy engine has no work outstanding. If a half credit and a full credit are both waiting, the consumer has outrun the writer. The transfer then stops and an error flag is raised.

While a transfer is active, a second request can be queued behind it. A request that starts where the active one ends is folded into the active one, but only if nothing is queued. A request that starts where the queued one ends extends the queued one. When the active request has been fully copied, the queued one takes over. A query port reports whether an address still waits to be copied. A flush input bounds how long a transfer may take to drain.

Top module: `ring_refill_ctrl`

## Requirements
- R1: After reset, `busy`, `overrun_flag`, `flush_timeout` and `query_pending` are 0 and `req_ready` is 1.
- R2: Each fetched byte b becomes the word {p, b}, with b in bits 7:0 and p in bit 8. p is 1 exactly when b has an even number of ones, so the word always has an odd count. `seq_word` shows the words in request byte order, and the ring index wraps modulo 256.
- R3: One byte is fetched per cycle while `mem_rd_ready` is 1, bytes remain in the active request, and the write position is below the fill limit. `mem_rd_en` is never 1 while idle.
- R4: The fill limit starts 256 ahead of write position 0. A take that moves the consumer from slot 127 to 128, or from slot 255 to 0, makes 128 slots of credit pending. The credit is granted in a cycle in which no fetch work is outstanding.
- R5: If a half-ring credit and a full-ring credit are pending together, the transfer stops (`busy` 0) and `overrun_flag` is 1 until the next start.
- R6: When fetching pauses with space left below the fill limit, the slot after the last valid word holds 9'h000. This is the encoding of zero with its parity bit inverted.
- R7: A request whose address equals the end of the active request, while nothing is queued, is accepted and extends the active request by its length.
- R8: With a request queued, a request contiguous with the queued one extends it. With the queue empty and no merge into the active request, a request becomes the queued one. Otherwise `req_ready` is 0 and the request waits.
- R9: Once every byte of the active request is fetched, a queued request becomes active with a cleared fetch count. Its bytes follow in the ring with no gap.
- R10: `query_pending` is 1 for an address between the fetch position and the end of the active request, or inside the queued request. It is 0 otherwise.
- R11: If `flush_req` is held while busy for TIMEOUT_CYC cycles, the transfer stops and `flush_timeout` is 1 until the next start.
- R12: `seq_done` with nothing queued returns the block to idle, with all positions cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A write request is offered |
| req_addr | input | ADDR_W | Request start address |
| req_len | input | LEN_W | Request byte count |
| req_ready | output | 1 | Request is taken this cycle |
| mem_rd_en | output | 1 | Byte fetch wanted |
| mem_rd_addr | output | ADDR_W | Byte fetch address |
| mem_rd_data | input | 8 | Fetched byte, same cycle |
| mem_rd_ready | input | 1 | Memory delivers this cycle |
| seq_word | output | 9 | Word at the consumer slot |
| seq_take | input | 1 | Consumer advances one slot |
| seq_done | input | 1 | Sequencer has finished |
| query_addr | input | ADDR_W | Address to test |
| query_pending | output | 1 | Address still waits to be fetched |
| flush_req | input | 1 | Wait-for-finish in progress |
| flush_timeout | output | 1 | Flush gave up, transfer stopped |
| busy | output | 1 | Transfer active |
| overrun_flag | output | 1 | Consumer outran the writer |

## Verification
On every cycle, the assertions check several properties. An overrun or flush timeout always coincides with the transfer stopping. The fetch count never passes the request length. No fetch and no pending query appear while idle. A queued request survives a merge into it, and `seq_done` with an empty queue ends the transfer. Only the bench scenarios can show the rest, because these depend on data values and orderings spread over hundreds of cycles. That covers the exact parity encoding of each word and the ring wrap across several credit grants. It also covers the poisoned slot after a partial fill, the byte order after merges and after promotion of a queued request, and the address windows reported by the query port.

// File: rtl/ring_pkg.sv
`timescale 1ns/1ps
package ring_pkg;
  localparam int WORD_W = 9;
  typedef logic [WORD_W-1:0] bus_word_t;

  // data in bits 7:0, bit 8 makes the total count of ones odd
  function automatic bus_word_t encode_byte(input logic [7:0] b);
    return {~^b, b};
  endfunction

  // encoding of zero with parity flipped: a consumer that runs ahead sees a parity error
  localparam bus_word_t POISON_WORD = 9'h000;
endpackage

// File: rtl/ring_store.sv
`timescale 1ns/1ps
module ring_store
  import ring_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int IDX_W = 8
)(
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  bus_word_t        wr_word,
  input  logic [IDX_W-1:0] rd_idx,
  output bus_word_t        rd_word
);
  bus_word_t slots [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) slots[wr_idx] <= wr_word;
  end

  assign rd_word = slots[rd_idx];
endmodule

// File: rtl/ring_credit.sv
`timescale 1ns/1ps
module ring_credit #(
  parameter int DEPTH = 256,
  parameter int IDX_W = 8,
  parameter int PTR_W = 9
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             take_en,
  input  logic [IDX_W-1:0] rd_lo,
  input  logic             work_pending,
  output logic [PTR_W-1:0] fill_to,
  output logic             overrun
);
  localparam logic [PTR_W-1:0] HALF_STEP = PTR_W'(DEPTH / 2);
  localparam logic [PTR_W-1:0] INIT_LIM  = PTR_W'(DEPTH);

  logic half_q, half_d, full_q, full_d;
  logic [PTR_W-1:0] lim_q, lim_d;
  logic at_edge, hit_half, hit_full, grant;

  always_comb begin
    at_edge  = take_en && (&rd_lo[IDX_W-2:0]);
    hit_half = at_edge && !rd_lo[IDX_W-1];
    hit_full = at_edge && rd_lo[IDX_W-1];
    grant    = !work_pending && (half_q ^ full_q);
    if (clr) begin
      half_d = 1'b0;
      full_d = 1'b0;
      lim_d  = INIT_LIM;
    end else begin
      half_d = (half_q && !grant) || hit_half;
      full_d = (full_q && !grant) || hit_full;
      lim_d  = grant ? lim_q + HALF_STEP : lim_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= 1'b0;
      full_q <= 1'b0;
      lim_q  <= INIT_LIM;
    end else begin
      half_q <= half_d;
      full_q <= full_d;
      lim_q  <= lim_d;
    end
  end

  assign fill_to = lim_q;
  assign overrun = half_q && full_q;
endmodule

// File: rtl/ring_watchdog.sv
`timescale 1ns/1ps
module ring_watchdog #(
  parameter int LIMIT = 4096,
  parameter int CNT_W = 13
)(
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  output logic expire
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    expire = arm && (cnt_q == CNT_W'(LIMIT - 1));
    cnt_d  = arm ? cnt_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ring_refill_ctrl.sv
`timescale 1ns/1ps
module ring_refill_ctrl
  import ring_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int LEN_W       = 16,
  parameter int DEPTH       = 256,
  parameter int TIMEOUT_CYC = 4096
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  output logic              req_ready,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [7:0]        mem_rd_data,
  input  logic              mem_rd_ready,
  output logic [8:0]        seq_word,
  input  logic              seq_take,
  input  logic              seq_done,
  input  logic [ADDR_W-1:0] query_addr,
  output logic              query_pending,
  input  logic              flush_req,
  output logic              flush_timeout,
  output logic              busy,
  output logic              overrun_flag
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int PTR_W = IDX_W + 1;
  localparam int TMO_W = $clog2(TIMEOUT_CYC + 1);

  logic              busy_q, busy_d;
  logic [ADDR_W-1:0] act_base_q, act_base_d;
  logic [LEN_W-1:0]  act_len_q, act_len_d;
  logic [LEN_W-1:0]  act_done_q, act_done_d;
  logic              q_valid_q, q_valid_d;
  logic [ADDR_W-1:0] q_base_q, q_base_d;
  logic [LEN_W-1:0]  q_len_q, q_len_d;
  logic [PTR_W-1:0]  wr_ptr_q, wr_ptr_d;
  logic [IDX_W-1:0]  rd_ptr_q, rd_ptr_d;
  logic              ovr_q, ovr_d, tmo_q, tmo_d;

  logic [PTR_W-1:0]  fill_to, space;
  logic [LEN_W-1:0]  remain;
  logic [ADDR_W-1:0] act_end, q_end, act_off, q_off;
  logic copy_work, copy_go, poison_go, promote, stop_now;
  logic ovr_hit, tmo_hit, join_act, join_q, fill_q, accept;
  bus_word_t wr_word;

  // datapath decode
  always_comb begin
    space     = fill_to - wr_ptr_q;
    remain    = act_len_q - act_done_q;
    copy_work = busy_q && (remain != '0) && (space != '0);
    copy_go   = copy_work && mem_rd_ready;
    poison_go = busy_q && !copy_go && (space != '0);
    promote   = busy_q && q_valid_q && (remain == '0);
    stop_now  = busy_q && (ovr_hit || tmo_hit || (seq_done && !q_valid_q));
    act_end   = act_base_q + ADDR_W'(act_len_q);
    q_end     = q_base_q + ADDR_W'(q_len_q);
    act_off   = query_addr - act_base_q;
    q_off     = query_addr - q_base_q;
    join_act  = busy_q && !q_valid_q && (req_addr == act_end);
    join_q    = busy_q && q_valid_q && (req_addr == q_end);
    fill_q    = busy_q && !q_valid_q && !join_act;
    req_ready = !busy_q || (!promote && !stop_now && (join_act || join_q || fill_q));
    accept    = req_valid && req_ready;
    wr_word   = copy_go ? encode_byte(mem_rd_data) : POISON_WORD;
  end

  // next state
  always_comb begin
    busy_d     = busy_q;
    act_base_d = act_base_q;
    act_len_d  = act_len_q;
    act_done_d = act_done_q;
    q_valid_d  = q_valid_q;
    q_base_d   = q_base_q;
    q_len_d    = q_len_q;
    wr_ptr_d   = wr_ptr_q;
    rd_ptr_d   = rd_ptr_q;
    ovr_d      = ovr_q;
    tmo_d      = tmo_q;
    if (!busy_q) begin
      if (accept) begin
        busy_d     = 1'b1;
        act_base_d = req_addr;
        act_len_d  = req_len;
        act_done_d = '0;
        q_valid_d  = 1'b0;
        wr_ptr_d   = '0;
        rd_ptr_d   = '0;
        ovr_d      = 1'b0;
        tmo_d      = 1'b0;
      end
    end else if (stop_now) begin
      busy_d     = 1'b0;
      act_base_d = '0;
      act_len_d  = '0;
      act_done_d = '0;
      q_valid_d  = 1'b0;
      q_base_d   = '0;
      q_len_d    = '0;
      wr_ptr_d   = '0;
      rd_ptr_d   = '0;
      ovr_d      = ovr_q || ovr_hit;
      tmo_d      = tmo_q || tmo_hit;
    end else begin
      if (copy_go) begin
        act_done_d = act_done_q + 1'b1;
        wr_ptr_d   = wr_ptr_q + 1'b1;
      end
      if (seq_take) rd_ptr_d = rd_ptr_q + 1'b1;
      if (promote) begin
        act_base_d = q_base_q;
        act_len_d  = q_len_q;
        act_done_d = '0;
        q_valid_d  = 1'b0;
        q_base_d   = '0;
        q_len_d    = '0;
      end else if (accept) begin
        if (join_act) begin
          act_len_d = act_len_q + req_len;
        end else if (join_q) begin
          q_len_d = q_len_q + req_len;
        end else begin
          q_valid_d = 1'b1;
          q_base_d  = req_addr;
          q_len_d   = req_len;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      act_base_q <= '0;
      act_len_q  <= '0;
      act_done_q <= '0;
      q_valid_q  <= 1'b0;
      q_base_q   <= '0;
      q_len_q    <= '0;
      wr_ptr_q   <= '0;
      rd_ptr_q   <= '0;
      ovr_q      <= 1'b0;
      tmo_q      <= 1'b0;
    end else begin
      busy_q     <= busy_d;
      act_base_q <= act_base_d;
      act_len_q  <= act_len_d;
      act_done_q <= act_done_d;
      q_valid_q  <= q_valid_d;
      q_base_q   <= q_base_d;
      q_len_q    <= q_len_d;
      wr_ptr_q   <= wr_ptr_d;
      rd_ptr_q   <= rd_ptr_d;
      ovr_q      <= ovr_d;
      tmo_q      <= tmo_d;
    end
  end

  ring_store #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
    .clk     (clk),
    .wr_en   (copy_go || poison_go),
    .wr_idx  (wr_ptr_q[IDX_W-1:0]),
    .wr_word (wr_word),
    .rd_idx  (rd_ptr_q),
    .rd_word (seq_word)
  );

  ring_credit #(.DEPTH(DEPTH), .IDX_W(IDX_W), .PTR_W(PTR_W)) u_credit (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr          (!busy_q),
    .take_en      (busy_q && seq_take),
    .rd_lo        (rd_ptr_q),
    .work_pending (copy_work),
    .fill_to      (fill_to),
    .overrun      (ovr_hit)
  );

  ring_watchdog #(.LIMIT(TIMEOUT_CYC), .CNT_W(TMO_W)) u_wd (
    .clk    (clk),
    .rst_n  (rst_n),
    .arm    (busy_q && flush_req),
    .expire (tmo_hit)
  );

  assign mem_rd_en     = copy_work;
  assign mem_rd_addr   = act_base_q + ADDR_W'(act_done_q);
  assign query_pending = busy_q &&
                         (((act_off >= ADDR_W'(act_done_q)) && (act_off < ADDR_W'(act_len_q))) ||
                          (q_valid_q && (q_off < ADDR_W'(q_len_q))));
  assign busy          = busy_q;
  assign overrun_flag  = ovr_q;
  assign flush_timeout = tmo_q;
endmodule

// File: rtl/ring_chk.sv
`timescale 1ns/1ps
module ring_chk #(
  parameter int LEN_W = 16
)(
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             overrun_flag,
  input logic             flush_timeout,
  input logic             seq_done,
  input logic             q_valid,
  input logic             req_valid,
  input logic             req_ready,
  input logic             mem_rd_en,
  input logic             query_pending,
  input logic [LEN_W-1:0] act_len,
  input logic [LEN_W-1:0] act_done
);
  assert_overrun_stops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun_flag) |-> !busy);

  assert_timeout_stops_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flush_timeout) |-> !busy);

  assert_idle_on_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && seq_done && !q_valid) |=> !busy);

  assert_fetch_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (act_done <= act_len));

  assert_no_fetch_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> busy);

  assert_idle_no_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !query_pending);

  assert_queue_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && q_valid && req_valid && req_ready) |=> q_valid);
endmodule

bind ring_refill_ctrl ring_chk #(.LEN_W(LEN_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .busy          (busy),
  .overrun_flag  (overrun_flag),
  .flush_timeout (flush_timeout),
  .seq_done      (seq_done),
  .q_valid       (q_valid_q),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .mem_rd_en     (mem_rd_en),
  .query_pending (query_pending),
  .act_len       (act_len_q),
  .act_done      (act_done_q)
);

// File: tb/sim_ring_refill_ctrl.sv
`timescale 1ns/1ps
module sim_ring_refill_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [15:0] req_addr = '0;
  logic [15:0] req_len = '0;
  logic        req_ready;
  logic        mem_rd_en;
  logic [15:0] mem_rd_addr;
  logic [7:0]  mem_rd_data;
  logic        mem_rd_ready = 1'b1;
  logic [8:0]  seq_word;
  logic        seq_take = 1'b0;
  logic        seq_done = 1'b0;
  logic [15:0] query_addr = '0;
  logic        query_pending;
  logic        flush_req = 1'b0;
  logic        flush_timeout;
  logic        busy;
  logic        overrun_flag;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  function automatic logic [7:0] mdata(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  function automatic logic [8:0] exp_word(input logic [7:0] b);
    int ones = 0;
    for (int k = 0; k < 8; k++) ones += int'(b[k]);
    return {((ones % 2) == 0) ? 1'b1 : 1'b0, b};
  endfunction

  assign mem_rd_data = mdata(mem_rd_addr);

  ring_refill_ctrl #(.ADDR_W(16), .LEN_W(16), .DEPTH(256), .TIMEOUT_CYC(50)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr), .req_len(req_len),
    .req_ready(req_ready), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .mem_rd_ready(mem_rd_ready), .seq_word(seq_word),
    .seq_take(seq_take), .seq_done(seq_done), .query_addr(query_addr),
    .query_pending(query_pending), .flush_req(flush_req), .flush_timeout(flush_timeout),
    .busy(busy), .overrun_flag(overrun_flag)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] a, input logic [15:0] n, output bit rdy);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_len = n;
    #1 rdy = req_ready;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic take_run(input logic [15:0] base, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(seq_word == exp_word(mdata(base + 16'(i))), tag, int'(seq_word),
          int'(exp_word(mdata(base + 16'(i)))));
      seq_take = 1'b1;
    end
    @(negedge clk);
    seq_take = 1'b0;
  endtask

  task automatic poison_chk(input string tag);
    @(negedge clk);
    chk(seq_word == 9'h000, tag, int'(seq_word), 0);
  endtask

  task automatic qry(input logic [15:0] a, input bit exp, input string tag);
    @(negedge clk);
    query_addr = a;
    #1 chk(query_pending == exp, tag, int'(query_pending), int'(exp));
  endtask

  task automatic finish_xfer(input string tag);
    @(negedge clk); seq_done = 1'b1;
    @(negedge clk); seq_done = 1'b0;
    #1 chk(busy == 1'b0, tag, int'(busy), 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    bit rdy;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 0, "R1 busy", int'(busy), 0);
    chk(overrun_flag == 0, "R1 overrun", int'(overrun_flag), 0);
    chk(flush_timeout == 0, "R1 timeout", int'(flush_timeout), 0);
    chk(query_pending == 0, "R1 pending", int'(query_pending), 0);
    chk(req_ready == 1, "R1 ready", int'(req_ready), 1);

    // R2 R3 R6 R7: short transfer, poison, merge into active
    send(16'h0100, 16'd10, rdy);
    repeat (15) @(negedge clk);
    chk(mem_rd_en == 0, "R3 fetch stops at length", int'(mem_rd_en), 0);
    take_run(16'h0100, 10, "R2 word");
    poison_chk("R6 poison after partial fill");
    send(16'h010A, 16'd6, rdy);
    chk(rdy == 1, "R7 merge accepted", int'(rdy), 1);
    repeat (10) @(negedge clk);
    take_run(16'h010A, 6, "R7 merged bytes");
    poison_chk("R6 poison after merge");
    qry(16'h0105, 0, "R10 copied address");
    qry(16'h010F, 0, "R10 address past end");
    finish_xfer("R12 idle on done");
    chk(query_pending == 0, "R12 idle no pending", int'(query_pending), 0);

    // R8 R9 R10: queueing with stalled memory
    mem_rd_ready = 1'b0;
    send(16'h0200, 16'd8, rdy);
    send(16'h0400, 16'd4, rdy);
    chk(rdy == 1, "R8 queued", int'(rdy), 1);
    qry(16'h0203, 1, "R10 active pending");
    qry(16'h0208, 0, "R10 beyond active");
    qry(16'h0402, 1, "R10 queued pending");
    qry(16'h0404, 0, "R10 beyond queued");
    send(16'h0404, 16'd2, rdy);
    chk(rdy == 1, "R8 queue extended", int'(rdy), 1);
    qry(16'h0405, 1, "R10 extended queue pending");
    qry(16'h0406, 0, "R10 beyond extended queue");
    @(negedge clk);
    req_valid = 1'b1; req_addr = 16'h0208; req_len = 16'd1;
    #1 chk(req_ready == 0, "R8 request waits", int'(req_ready), 0);
    @(negedge clk);
    req_valid = 1'b0;
    mem_rd_ready = 1'b1;
    repeat (30) @(negedge clk);
    qry(16'h0203, 0, "R10 fetched no longer pending");
    take_run(16'h0200, 8, "R9 first request");
    take_run(16'h0400, 6, "R9 promoted request");
    poison_chk("R6 poison after promotion");
    finish_xfer("R12 idle after chain");

    // R4 R2: long transfer across several credit grants and ring wraps
    send(16'h1000, 16'd600, rdy);
    repeat (262) @(negedge clk);
    chk(mem_rd_en == 0, "R4 writer halts at fill limit", int'(mem_rd_en), 0);
    take_run(16'h1000, 600, "R4 streamed word");
    chk(overrun_flag == 0, "R4 no overrun in stream", int'(overrun_flag), 0);
    finish_xfer("R12 idle after stream");

    // R5: consumer outruns a stalled writer
    mem_rd_ready = 1'b0;
    send(16'h2000, 16'd300, rdy);
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      if (i == 200) chk(busy == 1 && overrun_flag == 0, "R5 before overrun",
                        int'({busy, overrun_flag}), 2);
      seq_take = 1'b1;
    end
    @(negedge clk); seq_take = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy == 0, "R5 stopped", int'(busy), 0);
    chk(overrun_flag == 1, "R5 flag", int'(overrun_flag), 1);
    mem_rd_ready = 1'b1;

    // R11: flush timeout
    send(16'h0050, 16'd5, rdy);
    chk(overrun_flag == 0, "R5 flag cleared on start", int'(overrun_flag), 0);
    flush_req = 1'b1;
    repeat (30) @(negedge clk);
    chk(busy == 1, "R11 still waiting", int'(busy), 1);
    repeat (40) @(negedge clk);
    chk(busy == 0, "R11 stopped on timeout", int'(busy), 0);
    chk(flush_timeout == 1, "R11 timeout flag", int'(flush_timeout), 1);
    flush_req = 1'b0;
    send(16'h0060, 16'd3, rdy);
    chk(flush_timeout == 0, "R11 flag cleared on start", int'(flush_timeout), 0);
    finish_xfer("R12 idle after restart");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule